// File: doc/BRIEF.md
# SD Host Power Control Sequencer

This block sequences the power state of a card host interface. Software writes a 2-bit power-mode field, together with a direction-polarity bit, through a single-register write port. The stored mode decides how the card-side pads are driven. In the cycle mode every card line is pulled low, so the card cannot draw supply through its signal pins. In the off mode the host is disabled and every line is held high. In the on mode the card clock runs.

After the host enters the on mode, a preamble counter counts rising edges of the card clock. A ready flag rises when the count reaches the configured number, 74 by default. Until then the command and data lines stay parked high, and the command path must not start. Once ready, the pads pass the host's command and data values straight through.

The expected software order is cycle, then off, then on, with a wait of about 1 ms in the off mode. The block does not enforce either the order or the wait.

Top module: `sdpwr_seq`

## Requirements
- R1: After reset, the readback is 0x00 (mode code 00 = off), dir_pol is 0, host_ready is 0, and card_clk, card_cmd and all card_dat bits are 1.
- R2: A write whose bits [1:0] are 10 (cycle) drives card_clk, card_cmd and all card_dat bits to 0 from the cycle after the write edge. The readback then shows 10 in bits [1:0].
- R3: A write whose bits [1:0] are 00 (off) drives card_clk, card_cmd and all card_dat bits to 1 from the cycle after the write edge. host_ready is 0 in this mode.
- R4: A write whose bits [1:0] are 01 is ignored as a whole. The mode, the polarity bit, the readback and the pads keep their previous values.
- R5: Bit 4 of each accepted write is stored as the direction-polarity bit. It drives dir_pol and reads back at bit 4. All readback bits other than [1:0] and 4 read 0.
- R6: In the on mode (code 11) card_clk toggles every CLK_HALF_DIV system clocks. It starts low and first rises CLK_HALF_DIV system clocks after the write edge.
- R7: host_ready rises on the PREAMBLE_CLKS-th rising edge of card_clk after entering the on mode, that is (2*PREAMBLE_CLKS-1)*CLK_HALF_DIV clocks after the write edge. Before that, card_cmd and all card_dat bits are 1 whatever the host drives.
- R8: While host_ready is 1, card_cmd equals host_cmd and card_dat equals host_dat in the same cycle.
- R9: Leaving the on mode clears host_ready and stops card_clk in the next cycle. A later return to the on mode counts the preamble again from zero.
- R10: Writing the on code while already in the on mode neither restarts the preamble count nor clears host_ready.
- R11: Asserting rst in any mode returns the block to the state of R1 on the next clock edge.
- R12: The block does not enforce the mode order: a write of 11 while in the off mode is accepted directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe for the power register |
| reg_wdata | input | 8 | Write data: [1:0] mode, [4] polarity |
| reg_rdata | output | 8 | Readback of mode and polarity |
| host_cmd | input | 1 | Command-line value from the command path |
| host_dat | input | 8 | Data-line values from the data path |
| card_clk | output | 1 | Card clock pad |
| card_cmd | output | 1 | Card command pad |
| card_dat | output | 8 | Card data pads |
| dir_pol | output | 1 | Direction-polarity control |
| host_ready | output | 1 | Preamble done, command path may start |

## Verification
The bench builds the block with CLK_HALF_DIV set to 3 and PREAMBLE_CLKS left at 74. An odd divisor checks that the card-clock phase does not depend on a power-of-two counter wrap. With 74 preamble edges, the ready point lies at cycle 441 after the write. That point is reached within a few hundred cycles, so the bench can check the exact cycle of host_ready at the real count, both on a first entry and after a mid-preamble rewrite or a re-entry.

// File: rtl/sdpwr_pkg.sv
package sdpwr_pkg;

    localparam int REG_W   = 8;
    localparam int POL_BIT = 4;
    localparam int NUM_DAT = 8;

    typedef enum logic [1:0] {
        PM_OFF   = 2'b00,
        PM_RSVD  = 2'b01,
        PM_CYCLE = 2'b10,
        PM_ON    = 2'b11
    } pwr_mode_e;

    typedef struct packed {
        logic               clk;
        logic               cmd;
        logic [NUM_DAT-1:0] dat;
    } pad_drive_t;

    function automatic logic mode_legal(logic [1:0] code);
        return code != PM_RSVD;
    endfunction

    function automatic logic [REG_W-1:0] pack_status(pwr_mode_e m, logic pol);
        logic [REG_W-1:0] r;
        r          = '0;
        r[1:0]     = m;
        r[POL_BIT] = pol;
        return r;
    endfunction

    function automatic pad_drive_t pad_select(pwr_mode_e m, logic rdy, logic ck,
                                              logic hcmd, logic [NUM_DAT-1:0] hdat);
        pad_drive_t p;
        case (m)
            PM_CYCLE: p = '0;
            PM_ON: begin
                p.clk = ck;
                p.cmd = rdy ? hcmd : 1'b1;
                p.dat = rdy ? hdat : '1;
            end
            default:  p = '1;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/sdpwr_ctrl_reg.sv
module sdpwr_ctrl_reg
    import sdpwr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [REG_W-1:0] wdata,
    output pwr_mode_e        mode,
    output logic             pol
);

    logic unused_wdata_bits;
    assign unused_wdata_bits = ^{wdata[REG_W-1:POL_BIT+1], wdata[POL_BIT-1:2]};

    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= PM_OFF;
            pol  <= 1'b0;
        end else if (wr && mode_legal(wdata[1:0])) begin
            mode <= pwr_mode_e'(wdata[1:0]);
            pol  <= wdata[POL_BIT];
        end
    end

    // R4: a reserved code leaves mode and polarity untouched
    assert_reserved_ignored_R4: assert property (@(posedge clk) disable iff (rst)
        (wr && wdata[1:0] == 2'b01) |=> ($stable(mode) && $stable(pol)));

    // R5: without a write the polarity bit holds
    assert_pol_holds_R5: assert property (@(posedge clk) disable iff (rst)
        !wr |=> $stable(pol));

endmodule

// File: rtl/sdpwr_clk_div.sv
module sdpwr_clk_div #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic ck_q,
    output logic ck_rise
);

    localparam int DW = $clog2(HALF_DIV + 1);
    localparam logic [DW-1:0] LAST = DW'(HALF_DIV - 1);

    logic [DW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt  <= '0;
            ck_q <= 1'b0;
        end else if (cnt == LAST) begin
            cnt  <= '0;
            ck_q <= ~ck_q;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign ck_rise = run && (cnt == LAST) && !ck_q;

    // R9: the card clock parks low once the on mode is left
    assert_clk_parked_R9: assert property (@(posedge clk) disable iff (rst)
        !run |=> !ck_q);

    // R6: the clock only ever moves on a divider wrap
    assert_clk_step_R6: assert property (@(posedge clk) disable iff (rst)
        (run && cnt != LAST) |=> $stable(ck_q));

endmodule

// File: rtl/sdpwr_preamble.sv
module sdpwr_preamble #(
    parameter int PRE_CLKS = 74
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic ck_rise,
    output logic ready
);

    localparam int CW = $clog2(PRE_CLKS + 1);
    localparam logic [CW-1:0] DONE = CW'(PRE_CLKS);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt <= '0;
        else if (ck_rise && cnt != DONE)
            cnt <= cnt + 1'b1;
    end

    assign ready = run && (cnt == DONE);

    // R7: ready can only appear after a card clock rising edge
    assert_ready_on_edge_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> $past(ck_rise));

    // R7: the count saturates at the preamble length
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
        cnt <= DONE);

    // R10: once ready, staying in the on mode keeps it
    assert_ready_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        (ready && run) |=> (ready || !run));

endmodule

// File: rtl/sdpwr_seq.sv
module sdpwr_seq
    import sdpwr_pkg::*;
#(
    parameter int CLK_HALF_DIV  = 2,
    parameter int PREAMBLE_CLKS = 74
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_wr,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic [REG_W-1:0]   reg_rdata,
    input  logic               host_cmd,
    input  logic [NUM_DAT-1:0] host_dat,
    output logic               card_clk,
    output logic               card_cmd,
    output logic [NUM_DAT-1:0] card_dat,
    output logic               dir_pol,
    output logic               host_ready
);

    pwr_mode_e  mode;
    logic       pol;
    logic       run_ck;
    logic       ck_q;
    logic       ck_rise;
    logic       rdy;
    pad_drive_t pads;

    sdpwr_ctrl_reg u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .wr    (reg_wr),
        .wdata (reg_wdata),
        .mode  (mode),
        .pol   (pol)
    );

    assign run_ck = (mode == PM_ON);

    sdpwr_clk_div #(.HALF_DIV(CLK_HALF_DIV)) u_div (
        .clk     (clk),
        .rst     (rst),
        .run     (run_ck),
        .ck_q    (ck_q),
        .ck_rise (ck_rise)
    );

    sdpwr_preamble #(.PRE_CLKS(PREAMBLE_CLKS)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .run     (run_ck),
        .ck_rise (ck_rise),
        .ready   (rdy)
    );

    always_comb pads = pad_select(mode, rdy, ck_q, host_cmd, host_dat);

    assign card_clk   = pads.clk;
    assign card_cmd   = pads.cmd;
    assign card_dat   = pads.dat;
    assign dir_pol    = pol;
    assign host_ready = rdy;
    assign reg_rdata  = pack_status(mode, pol);

    // R2: the cycle mode holds every card line low
    assert_cycle_low_R2: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata[1:0] == 2'b10) |-> (!card_clk && !card_cmd && card_dat == '0));

    // R3: the off mode holds every card line high and the host not ready
    assert_off_high_R3: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata[1:0] == 2'b00) |-> (card_clk && card_cmd && &card_dat && !host_ready));

    // R7: during the preamble command and data stay parked high
    assert_preamble_park_R7: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata[1:0] == 2'b11 && !host_ready) |-> (card_cmd && &card_dat));

    // R11: reset always lands in the off state with polarity cleared
    assert_reset_state_R11: assert property (@(posedge clk)
        rst |=> (reg_rdata == '0 && !host_ready));

endmodule

// File: tb/test_sdpwr_seq.sv
module test_sdpwr_seq;
    import sdpwr_pkg::*;

    localparam int DIV = 3;
    localparam int PRE = 74;
    localparam int RDY = (2 * PRE - 1) * DIV;
    localparam int NV  = 7;

    // fields: [26:19] wdata, [18:11] rdata, [10] pol, [9] clk, [8] cmd, [7:0] dat
    localparam logic [26:0] VEC [NV] = '{
        {8'h02, 8'h02, 1'b0, 1'b0, 1'b0, 8'h00},
        {8'h01, 8'h02, 1'b0, 1'b0, 1'b0, 8'h00},
        {8'h12, 8'h12, 1'b1, 1'b0, 1'b0, 8'h00},
        {8'hEE, 8'h02, 1'b0, 1'b0, 1'b0, 8'h00},
        {8'h00, 8'h00, 1'b0, 1'b1, 1'b1, 8'hFF},
        {8'h11, 8'h00, 1'b0, 1'b1, 1'b1, 8'hFF},
        {8'h13, 8'h13, 1'b1, 1'b0, 1'b1, 8'hFF}
    };
    string vtag [NV] = '{"R2", "R4", "R5", "R5", "R3", "R4", "R12"};

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               reg_wr = 1'b0;
    logic [REG_W-1:0]   reg_wdata = '0;
    logic [REG_W-1:0]   reg_rdata;
    logic               host_cmd = 1'b0;
    logic [NUM_DAT-1:0] host_dat = '0;
    logic               card_clk, card_cmd, dir_pol, host_ready;
    logic [NUM_DAT-1:0] card_dat;

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;
    int t0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sdpwr_seq #(.CLK_HALF_DIV(DIV), .PREAMBLE_CLKS(PRE)) i_sdpwr_seq (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .host_cmd(host_cmd), .host_dat(host_dat),
        .card_clk(card_clk), .card_cmd(card_cmd), .card_dat(card_dat),
        .dir_pol(dir_pol), .host_ready(host_ready)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic write_reg(logic [7:0] v);
        @(negedge clk);
        reg_wr    = 1'b1;
        reg_wdata = v;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic wait_to(int target);
        while (cyc != target) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 rdata", reg_rdata, 8'h00);
        check("R1 pol", dir_pol, 1'b0);
        check("R1 ready", host_ready, 1'b0);
        check("R1 pads", {card_clk, card_cmd, card_dat}, 10'h3FF);

        // table walk: mode writes from off, incl. reserved and polarity
        for (int i = 0; i < NV; i++) begin
            write_reg(VEC[i][26:19]);
            check({vtag[i], " rdata"}, reg_rdata, VEC[i][18:11]);
            check({vtag[i], " pol"}, dir_pol, VEC[i][10]);
            check({vtag[i], " pads"}, {card_clk, card_cmd, card_dat}, VEC[i][9:0]);
        end

        // R11 reset from on mode
        do_reset();
        check("R11 rdata", reg_rdata, 8'h00);
        check("R11 ready", host_ready, 1'b0);
        check("R11 pads", {card_clk, card_cmd, card_dat}, 10'h3FF);

        // R6 clock phase, R7 ready point, R8 pass-through
        write_reg(8'h03);
        t0 = cyc;
        wait_to(t0 + DIV - 1);
        check("R6 clk low before first rise", card_clk, 1'b0);
        wait_to(t0 + DIV);
        check("R6 first rise", card_clk, 1'b1);
        wait_to(t0 + 2 * DIV);
        check("R6 first fall", card_clk, 1'b0);
        wait_to(t0 + RDY - 1);
        check("R7 not ready yet", host_ready, 1'b0);
        check("R7 parked pads", {card_cmd, card_dat}, 9'h1FF);
        wait_to(t0 + RDY);
        check("R7 ready", host_ready, 1'b1);
        check("R8 cmd follows host", card_cmd, 1'b0);
        host_cmd = 1'b1;
        host_dat = 8'hA5;
        #1;
        check("R8 pass A5", {card_cmd, card_dat}, 9'h1A5);
        host_dat = 8'h3C;
        #1;
        check("R8 pass 3C", card_dat, 8'h3C);

        // R10 rewrite on while ready
        write_reg(8'h03);
        check("R10 ready kept", host_ready, 1'b1);

        // R9 leave on mode and re-enter
        write_reg(8'h02);
        check("R9 ready cleared", host_ready, 1'b0);
        check("R9 pads low", {card_clk, card_cmd, card_dat}, 10'h000);
        write_reg(8'h03);
        t0 = cyc;
        wait_to(t0 + RDY - 1);
        check("R9 recount not ready", host_ready, 1'b0);
        wait_to(t0 + RDY);
        check("R9 recount ready", host_ready, 1'b1);

        // R10 rewrite during the preamble keeps the count
        write_reg(8'h00);
        check("R3 off after on", {card_clk, card_cmd, card_dat, host_ready}, 11'h7FE);
        write_reg(8'h03);
        t0 = cyc;
        wait_to(t0 + 50);
        write_reg(8'h03);
        wait_to(t0 + RDY - 1);
        check("R10 mid rewrite not ready", host_ready, 1'b0);
        wait_to(t0 + RDY);
        check("R10 mid rewrite ready", host_ready, 1'b1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        wait (cyc > 20000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule